// File: doc/BRIEF.md
# MDIO Management Command Engine

This block carries out clause-22 management transactions to an external PHY. Each transaction is launched by a single 32-bit command word. Software writes one word that holds the opcode, the PHY address, the PHY register address and, for writes, 16 bits of data. The engine then sends a complete frame on the management clock and data pins. A read transaction places the 16 bits returned by the PHY into the data field of the same register.

Completion is signalled by a ready bit that hardware sets. An optional level interrupt also marks the end of a transaction. While a frame is in flight, ready reads 0 and any further command write is discarded. The management clock is derived from the system clock by a divider parameter, `DIV_HALF`, which gives the number of system clocks in each half period.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The read-back word is laid out as follows: data in bits 15:0, PHY register address in 20:16, PHY address in 25:21, opcode in 27:26, ready in bit 28, interrupt enable in bit 29. Bits 31:30 always read 0. After a transaction, the word reads back the issued fields with ready set.
- R2: Opcode 2'b01 starts a write and opcode 2'b10 starts a read. A write with opcode 2'b00 or 2'b11 while idle produces no frame. It updates only the interrupt-enable bit and leaves the other fields and ready unchanged.
- R3: Each frame is 64 bit times, in this order: 32 ones, start bits 0 then 1, 2 opcode bits, 5 PHY-address bits, 5 register-address bits, 2 turnaround bits, 16 data bits. Every field is sent MSB first. On a write the turnaround is driven as 1 then 0.
- R4: A write shifts the data field out MSB first. A read captures the 16 bits received from the PHY, MSB first, into the data field. The captured value is readable once ready is set.
- R5: `mdc` has a period of 2*DIV_HALF system clocks and is held low when idle. `mdio_o` changes only on the clock following a falling `mdc`. Read data is sampled on the rising `mdc`.
- R6: Ready is 1 after reset. It is cleared by an accepted command, stays 0 for the whole frame, and is set again when the frame ends.
- R7: A command write that arrives while a frame is in flight is ignored. It starts no frame and changes no field.
- R8: `irq` is a level output. It rises at the end of a transaction when interrupt enable is 1. It clears when a new command is accepted or when a word with interrupt enable 0 is written while idle.
- R9: After reset, the register reads 32'h1000_0000, and `irq`, `mdc` and `mdio_oe` are all 0.
- R10: On a read, `mdio_oe` is 0 from the first turnaround bit through the last data bit. On a write, `mdio_oe` is 1 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Command register read-back |
| irq | output | 1 | Level interrupt for end of transaction |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data received from the PHY |

## Verification
The hardest case to reach from the ports is a command write that lands in the middle of a frame. The ignore rule and the unchanged register can only be seen once the earlier frame has finished. To reach it, the stimulus writes a first command, waits a few dozen clocks into its preamble, and writes a conflicting second command. It then confirms three things: exactly one frame crossed the pins, it matched the first command, and the read-back after completion still holds the first command's fields.

A bench PHY model drives the returned data so that read capture and the turnaround release can be compared bit by bit.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// mdio_pkg: shared opcode type and frame geometry for the MDIO command engine.
// Assumes clause-22 framing with a full 32-bit preamble.
package mdio_pkg;
    typedef enum logic [1:0] {
        OP_RSV0  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSV3  = 2'b11
    } mdio_op_e;

    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int DATA_IDX   = 48;   // first data bit
    localparam int IDX_W      = $clog2(FRAME_BITS);
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
// mdio_clk_gen: management clock divider.
// Runs only while enabled; mdc rests low. Produces single-cycle strobes
// on the system clock edge where mdc rises or falls.
// Assumes DIV_HALF >= 1.
module mdio_clk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == LAST);
    assign rise_stb = en && wrap && !mdc;
    assign fall_stb = en && wrap && mdc;

    // Half-period counter and mdc toggle; parked low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !$past(en) |-> !mdc) else $error("mdc not parked low"); // R5
endmodule

// File: rtl/mdio_frame_shifter.sv
`timescale 1ns/1ps
// mdio_frame_shifter: serialises one 64-bit management frame.
// Loads the whole frame on start and shifts it on each falling mdc.
// On reads, releases the line from the turnaround onward and captures
// the data bits on rising mdc.
// Assumes start is only pulsed while not busy.
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  is_rd;
    logic [15:0]           cap;

    assign done    = busy && fall_stb && (idx == LAST_IDX);
    assign mdio_oe = busy && !(is_rd && idx >= IDX_W'(TA_IDX));
    assign mdio_o  = mdio_oe ? shreg[FRAME_BITS-1] : 1'b1;
    assign rdata   = cap;

    // Frame load, bit advance on falling mdc, and end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            shreg <= '0;
            is_rd <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            shreg <= {32'hFFFF_FFFF, 2'b01, op, phy, regad, 2'b10, wdata};
            is_rd <= (op == OP_READ);
        end else if (busy && fall_stb) begin
            if (idx == LAST_IDX) busy <= 1'b0;
            else                 idx  <= idx + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
    end

    // Read capture on rising mdc during the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cap <= '0;
        end else if (busy && rise_stb && is_rd && idx >= IDX_W'(DATA_IDX)) begin
            cap <= {cap[14:0], mdio_i};
        end
    end

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$stable(mdio_o) |-> $past(fall_stb))
        else $error("mdio_o moved off a falling edge"); // R5
    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$stable(cap) |-> $past(rise_stb))
        else $error("capture off a rising edge"); // R5
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && is_rd && idx >= IDX_W'(TA_IDX) |-> !mdio_oe)
        else $error("line driven during read data"); // R10
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
// mdio_cmd_engine: command register front end of the MDIO master.
// A valid command written while idle latches the fields, clears ready
// and launches a frame. Ready returns at the end of the frame, read
// data is merged in, and the level interrupt is raised if enabled.
// Assumes software writes reserved bits and the ready bit as 0 in a command.
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [15:0] f_data;
    logic [4:0]  f_reg;
    logic [4:0]  f_phy;
    mdio_op_e    f_op;
    logic        f_rdy;
    logic        f_ie;
    logic        irq_flag;

    logic        busy, done, rise_stb, fall_stb, start, op_ok;
    logic [15:0] rd_data;
    mdio_op_e    wr_op;

    assign wr_op     = mdio_op_e'(reg_wdata[27:26]);
    assign op_ok     = (wr_op == OP_WRITE) || (wr_op == OP_READ);
    assign start     = reg_wr && !busy && op_ok;
    assign irq       = irq_flag && f_ie;
    assign reg_rdata = {2'b00, f_ie, f_rdy, f_op, f_phy, f_reg, f_data};

    mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(busy),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .op(wr_op),
        .phy(reg_wdata[25:21]), .regad(reg_wdata[20:16]), .wdata(reg_wdata[15:0]),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(busy), .done(done), .rdata(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // Command register: accept, reserved-opcode IE update, completion merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_data   <= '0;
            f_reg    <= '0;
            f_phy    <= '0;
            f_op     <= OP_RSV0;
            f_rdy    <= 1'b1;
            f_ie     <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (start) begin
                f_data   <= reg_wdata[15:0];
                f_reg    <= reg_wdata[20:16];
                f_phy    <= reg_wdata[25:21];
                f_op     <= wr_op;
                f_ie     <= reg_wdata[29];
                f_rdy    <= 1'b0;
                irq_flag <= 1'b0;
            end else if (reg_wr && !busy) begin
                f_ie <= reg_wdata[29];
                if (!reg_wdata[29]) irq_flag <= 1'b0;
            end
            if (done) begin
                f_rdy <= 1'b1;
                if (f_op == OP_READ) f_data <= rd_data;
                if (f_ie) irq_flag <= 1'b1;
            end
        end
    end

    AST_SW_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_wdata[31:30] == 2'b00 && !(op_ok && reg_wdata[28]))
        else $error("command word breaks software rules"); // R1
    AST_START_VALID_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr) && ($past(reg_wdata[27:26]) == 2'b01 ||
                                          $past(reg_wdata[27:26]) == 2'b10))
        else $error("frame without valid opcode"); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !f_rdy) else $error("ready during frame"); // R6
    AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> f_rdy) else $error("ready missing at end"); // R6
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && $past(reg_wr) && busy |-> $stable(reg_rdata))
        else $error("busy write changed register"); // R7
    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> f_ie && f_rdy) else $error("irq while busy or disabled"); // R8
endmodule

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
// sim_mdio_cmd_engine: scoreboard bench. The driver pushes expected frames,
// a monitor with a PHY model reassembles frames from the pins and compares.
module sim_mdio_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_err = 0;
    int frames = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];
    logic [31:0] shadow;

    mdio_cmd_engine #(.DIV_HALF(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
        return {1'b1, p, r, 5'b01101};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    endtask

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_ready;
        for (int i = 0; i < 3000 && !reg_rdata[28]; i++) @(negedge clk);
    endtask

    // Driver: push expected frame, issue command, check completion state.
    task automatic issue(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic ie);
        logic [15:0] ed;
        ed = (op == 2'b10) ? phy_val(p, r) : d;
        exp_q.push_back({32'hFFFF_FFFF, 2'b01, op, p, r, 2'b10, ed});
        write_reg({2'b00, ie, 1'b0, op, p, r, d});
        chk("R6 ready cleared on accept", reg_rdata[28], 1'b0);
        chk("R8 irq cleared by new command", irq, 1'b0);
        wait_ready;
        shadow = {2'b00, ie, 1'b1, op, p, r, ed};
        chk("R1/R4 readback after frame", reg_rdata, shadow);
        chk("R8 irq level at end", irq, ie);
    endtask

    // Monitor and PHY model: collect 64 bits per frame, drive read data.
    initial begin
        forever begin
            logic [63:0] obs;
            logic        rd;
            logic        oe_bad;
            logic [15:0] rv;
            time         t0;
            rd = 0; oe_bad = 0; rv = '0; obs = '0; t0 = 0;
            @(posedge mdio_oe);
            for (int k = 0; k < 64; k++) begin
                @(posedge mdc);
                obs[63-k] = mdio_oe ? mdio_o : mdio_i;
                if (k == 0) t0 = $time;
                if (k == 1) chk("R5 mdc period", 64'($time - t0), 64'(2*DIV*CLK_PERIOD));
                if (k == 35) rd = (obs[29:28] == 2'b10);
                if (k == 45) rv = phy_val(obs[27:23], obs[22:18]);
                if (k >= 46 && (mdio_oe !== !rd)) oe_bad = 1;
                if (k < 46 && mdio_oe !== 1'b1) oe_bad = 1;
                @(negedge mdc);
                if (rd && k + 1 == 47)      mdio_i = 1'b0;
                else if (rd && k + 1 >= 48 && k + 1 < 64) mdio_i = rv[15-(k+1-48)];
                else                        mdio_i = 1'b1;
            end
            frames++;
            chk("R10 output enable pattern", oe_bad, 1'b0);
            if (exp_q.size() == 0) chk("R2/R7 unexpected frame", obs, 64'h0);
            else chk("R3 frame bits", obs, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset register", reg_rdata, 32'h1000_0000);
        chk("R9 reset pins", {irq, mdc, mdio_oe}, 3'b000);

        issue(2'b01, 5'd5, 5'd3, 16'hA5C3, 1'b0);           // R2 R3 R4 write
        issue(2'b10, 5'h1F, 5'd0, 16'h0000, 1'b1);          // R4 read with irq R8
        issue(2'b01, 5'd0, 5'h1F, 16'h8001, 1'b1);          // R3 edge addresses
        issue(2'b10, 5'd9, 5'd17, 16'hFFFF, 1'b1);          // R4 read, stale data field

        // R2/R8: reserved opcode 00 with IE=0 clears irq, no frame.
        f0 = frames;
        write_reg({2'b00, 1'b0, 1'b0, 2'b00, 5'd1, 5'd2, 16'h1234});
        shadow[29] = 1'b0;
        chk("R8 irq cleared by IE=0", irq, 1'b0);
        chk("R2 reserved op keeps fields", reg_rdata, shadow);
        // R2: reserved opcode 11 sets only IE.
        write_reg({2'b00, 1'b1, 1'b0, 2'b11, 5'd7, 5'd7, 16'h7777});
        shadow[29] = 1'b1;
        chk("R2 reserved op 11 only IE", reg_rdata, shadow);
        chk("R8 irq stays low", irq, 1'b0);
        repeat (500) @(negedge clk);
        chk("R2 no frame for reserved op", frames, f0);

        // R7: second command during a frame is ignored.
        f0 = frames;
        exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'd12, 5'd6, 2'b10, 16'h3C5A});
        write_reg({2'b00, 1'b0, 1'b0, 2'b01, 5'd12, 5'd6, 16'h3C5A});
        repeat (40) @(negedge clk);
        chk("R6 ready low mid frame", reg_rdata[28], 1'b0);
        write_reg({2'b00, 1'b1, 1'b0, 2'b10, 5'd3, 5'd4, 16'h0F0F});
        wait_ready;
        chk("R7 fields of first command", reg_rdata,
            {2'b00, 1'b0, 1'b1, 2'b01, 5'd12, 5'd6, 16'h3C5A});
        repeat (500) @(negedge clk);
        chk("R7 single frame", frames, f0 + 1);
        chk("R7 scoreboard drained", exp_q.size(), 0);
        chk("R5 mdc idle low", mdc, 1'b0);
        finish_run;
    end
endmodule